// File: doc/BRIEF.md
# Serial (7,4) Cyclic Code Encoder and Decoder

This block protects 4-bit data words with a (7,4) cyclic code whose generator is G(x) = x^3 + x + 1. The code is non-separable: the 7-bit codeword is the modulo-2 product D(x)·G(x), so the data bits do not appear as a field of the codeword. Any two codewords differ in at least 3 positions.

The encoder multiplies by G(x) with a three-stage shift register and XOR taps. It takes one data bit per clock, highest-degree coefficient first. After the 4 data bits it shifts in 3 zeros of its own, so one word takes 7 clocks. The decoder divides a received 7-bit stream by G(x), also highest-degree coefficient first. It emits the 4 quotient bits, which are the recovered data for a valid codeword. After the seventh bit its three registers hold the remainder, and this remainder is the syndrome. A zero syndrome marks a valid codeword and a nonzero one raises the error flag. The block does not correct errors. Both halves start on a one-cycle start pulse that also clears their shift registers.

Top module: `cyc74_codec`

## Requirements
- R1: The encoder, started with data d3..d0 given on `enc_bit` in the start cycle and the 3 cycles after it, presents the 7 coefficients of D(x)·G(x), highest degree (v6) first, on `enc_code` with `enc_valid` high. They appear in the 7 cycles that follow the start cycle. Data 1011 gives 1000101 and data 1111 gives 1101001.
- R2: Values on `enc_bit` in the 3 cycles after the 4 data bits do not affect the codeword. The encoder shifts zeros in their place.
- R3: `enc_last` is high together with the seventh code bit only.
- R4: The decoder, started with v6 on `dec_bit` in the start cycle and the next 6 bits in the 6 cycles after it, emits exactly 4 quotient bits on `dec_qbit` with `dec_qvalid` high. They come highest degree first, in cycles 4 to 7 after the start cycle. For a valid codeword they equal d3..d0.
- R5: `dec_done` pulses for one cycle, 7 cycles after the start cycle. In that cycle `dec_syn` holds the 3-bit remainder of the received word divided by G(x), with bit 2 the x^2 coefficient, and `dec_err` is 1 exactly when that remainder is nonzero.
- R6: Every single-bit error in a codeword gives a nonzero syndrome and `dec_err` = 1.
- R7: A start pulse clears the shift registers and aborts any word in progress. A new word may start in the cycle after the previous word's `enc_last` or `dec_done`, and the earlier word has no effect on it.
- R8: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_start | input | 1 | Starts an encode; `enc_bit` carries d3 in this cycle |
| enc_bit | input | 1 | Serial data in, highest degree first |
| enc_code | output | 1 | Serial codeword bit |
| enc_valid | output | 1 | `enc_code` is valid |
| enc_last | output | 1 | Seventh code bit of the word |
| dec_start | input | 1 | Starts a decode; `dec_bit` carries v6 in this cycle |
| dec_bit | input | 1 | Serial received bit, highest degree first |
| dec_qbit | output | 1 | Serial quotient (recovered data) bit |
| dec_qvalid | output | 1 | `dec_qbit` is valid |
| dec_done | output | 1 | Word finished; syndrome and error flag valid |
| dec_err | output | 1 | Nonzero syndrome, valid with `dec_done` |
| dec_syn | output | 3 | Remainder left in the divider registers |

## Verification
The assertions check on every cycle the framing relations. The last code bit comes with a valid strobe, and the done pulse comes with the final quotient bit. The error flag appears only with done and agrees with the held syndrome. A start clears the upper divider stages. Only the bench scenarios can show the arithmetic. These cover the exact product codeword for all 16 data words with random flush noise, the quotient and remainder for random received words, and a nonzero syndrome for each of the 112 single-bit corruptions. They also cover aborts in mid-word and back-to-back words where a faulty word is followed by a clean one.

// File: rtl/cyc_pkg.sv
// Shared defaults and helpers for the serial cyclic codec.
// Assumes: generator polynomials are monic and at most 32 bits wide.
package cyc_pkg;

    localparam int DEF_DATA_W = 4;
    localparam int DEF_CHK_W  = 3;
    // Generator x^3 + x + 1, bit i is the x^i coefficient.
    localparam logic [DEF_CHK_W:0] DEF_GEN = 4'b1011;

    // Modulo-2 sum of the bits of a selected by mask m.
    function automatic logic masked_xor(input logic [31:0] a, input logic [31:0] m);
        return ^(a & m);
    endfunction

endpackage

// File: rtl/cyc_seq.sv
// Step sequencer: counts the LEN serial steps of one word.
// A start pulse is step 0 and restarts any word in progress.
// Assumes: LEN >= 2.
module cyc_seq #(
    parameter int LEN = 7,
    parameter int IW  = $clog2(LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          active,
    output logic [IW-1:0] idx,
    output logic          last
);

    logic          busy;
    logic [IW-1:0] cnt;

    // Step counter: start loads step 1 for the next cycle, busy advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= IW'(1);
        end else if (busy) begin
            if (cnt == IW'(LEN - 1)) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + IW'(1);
            end
        end
    end

    // Current step: a start always means step 0.
    always_comb begin
        active = start | busy;
        idx    = start ? '0 : cnt;
        last   = active && (idx == IW'(LEN - 1));
    end

endmodule

// File: rtl/cyc_ser_mul.sv
// Serial polynomial multiplier (encoder): streams D(x)*GEN(x),
// highest coefficient first, one bit per clock. Data bits are taken
// in steps 0..K-1. Steps K..K+R-1 shift zeros regardless of din.
// Assumes: R >= 2, GEN monic of degree R.
module cyc_ser_mul #(
    parameter int           K   = cyc_pkg::DEF_DATA_W,
    parameter int           R   = cyc_pkg::DEF_CHK_W,
    parameter logic [R:0]   GEN = cyc_pkg::DEF_GEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic din,
    output logic code,
    output logic valid,
    output logic last
);

    localparam int N  = K + R;
    localparam int IW = $clog2(N + 1);

    logic          act, lst;
    logic [IW-1:0] idx;
    logic [R-1:0]  hist;      // hist[0] is the most recent input bit
    logic [R-1:0]  hsel;
    logic [R-1:0]  hrev;
    logic          u;
    logic          prod;
    logic          code_q, valid_q, last_q;

    cyc_seq #(.LEN(N), .IW(IW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (act),
        .idx    (idx),
        .last   (lst)
    );

    // Product bit: g_R*u plus g_(R-i) times the input from i steps back.
    always_comb begin
        u    = act && (idx < IW'(K)) ? din : 1'b0;
        hsel = start ? '0 : hist;
        for (int j = 0; j < R; j++) hrev[j] = hsel[R-1-j];
        prod = (GEN[R] & u) ^ cyc_pkg::masked_xor(32'(hrev), 32'(GEN[R-1:0]));
    end

    // Input history shift register, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist <= '0;
        else if (act) hist <= {hsel[R-2:0], u};
    end

    // Registered serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= 1'b0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            code_q  <= act & prod;
            valid_q <= act;
            last_q  <= lst;
        end
    end

    assign code  = code_q;
    assign valid = valid_q;
    assign last  = last_q;

    AST_ENC_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_q |-> valid_q); // R3
    AST_ENC_START_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid_q); // R1
    AST_ENC_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> !code_q); // R1

endmodule

// File: rtl/cyc_ser_div.sv
// Serial polynomial divider (decoder): divides the received stream
// by GEN(x), highest coefficient first. Emits the quotient bits from
// step R on and leaves the remainder (syndrome) in its registers.
// Assumes: R >= 2, GEN monic of degree R, word length K+R.
module cyc_ser_div #(
    parameter int           K   = cyc_pkg::DEF_DATA_W,
    parameter int           R   = cyc_pkg::DEF_CHK_W,
    parameter logic [R:0]   GEN = cyc_pkg::DEF_GEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         din,
    output logic         qbit,
    output logic         qvalid,
    output logic         done,
    output logic         err,
    output logic [R-1:0] syn
);

    localparam int N  = K + R;
    localparam int IW = $clog2(N + 1);

    logic          act, lst;
    logic [IW-1:0] idx;
    logic [R-1:0]  rem;
    logic [R-1:0]  rsel;
    logic [R-1:0]  rnext;
    logic          q;
    logic          qbit_q, qvalid_q, done_q, err_q;

    cyc_seq #(.LEN(N), .IW(IW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (act),
        .idx    (idx),
        .last   (lst)
    );

    // Division step: the top stage is the quotient bit and selects the subtraction.
    always_comb begin
        rsel  = start ? '0 : rem;
        q     = rsel[R-1];
        rnext = {rsel[R-2:0], din} ^ (q ? GEN[R-1:0] : '0);
    end

    // Remainder register, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n)   rem <= '0;
        else if (act) rem <= rnext;
    end

    // Registered quotient stream, done pulse and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qbit_q   <= 1'b0;
            qvalid_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            qvalid_q <= act && (idx >= IW'(R));
            qbit_q   <= act && (idx >= IW'(R)) && q;
            done_q   <= lst;
            err_q    <= lst && (|rnext);
        end
    end

    assign qbit   = qbit_q;
    assign qvalid = qvalid_q;
    assign done   = done_q;
    assign err    = err_q;
    assign syn    = rem;

    AST_DEC_DONE_QBIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> qvalid_q); // R4
    AST_DEC_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q); // R5
    AST_DEC_SYN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (err_q == (rem != '0))); // R5
    AST_DEC_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rem[R-1:1] == '0)); // R7

endmodule

// File: rtl/cyc74_codec.sv
// Serial (7,4) cyclic codec top: a multiplying encoder and a dividing
// decoder for GEN(x) = x^3 + x + 1, running independently.
// Assumes: callers pulse start for one cycle with the first bit.
module cyc74_codec #(
    parameter int                    DATA_W   = cyc_pkg::DEF_DATA_W,
    parameter int                    CHK_W    = cyc_pkg::DEF_CHK_W,
    parameter logic [CHK_W:0]        GEN_POLY = cyc_pkg::DEF_GEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_start,
    input  logic             enc_bit,
    output logic             enc_code,
    output logic             enc_valid,
    output logic             enc_last,
    input  logic             dec_start,
    input  logic             dec_bit,
    output logic             dec_qbit,
    output logic             dec_qvalid,
    output logic             dec_done,
    output logic             dec_err,
    output logic [CHK_W-1:0] dec_syn
);

    cyc_ser_mul #(.K(DATA_W), .R(CHK_W), .GEN(GEN_POLY)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (enc_start),
        .din   (enc_bit),
        .code  (enc_code),
        .valid (enc_valid),
        .last  (enc_last)
    );

    cyc_ser_div #(.K(DATA_W), .R(CHK_W), .GEN(GEN_POLY)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (dec_start),
        .din    (dec_bit),
        .qbit   (dec_qbit),
        .qvalid (dec_qvalid),
        .done   (dec_done),
        .err    (dec_err),
        .syn    (dec_syn)
    );

endmodule

// File: tb/tb_cyc74_codec.sv
module tb_cyc74_codec;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst_n, enc_start, enc_bit, dec_start, dec_bit;
    logic       enc_code, enc_valid, enc_last;
    logic       dec_qbit, dec_qvalid, dec_done, dec_err;
    logic [2:0] dec_syn;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [3:0] G = 4'b1011;

    cyc74_codec dut (
        .clk(clk), .rst_n(rst_n),
        .enc_start(enc_start), .enc_bit(enc_bit),
        .enc_code(enc_code), .enc_valid(enc_valid), .enc_last(enc_last),
        .dec_start(dec_start), .dec_bit(dec_bit),
        .dec_qbit(dec_qbit), .dec_qvalid(dec_qvalid), .dec_done(dec_done),
        .dec_err(dec_err), .dec_syn(dec_syn)
    );

    function automatic logic [6:0] mulg(input logic [3:0] d);
        logic [6:0] v = '0;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                if (d[i] & G[j]) v[i+j] = ~v[i+j];
        return v;
    endfunction

    function automatic logic [2:0] remg(input logic [6:0] w);
        logic [6:0] t = w;
        for (int k = 6; k >= 3; k--)
            if (t[k]) t[k-:4] = t[k-:4] ^ G;
        return t[2:0];
    endfunction

    function automatic logic [3:0] quog(input logic [6:0] w);
        logic [6:0] t = w;
        logic [3:0] q = '0;
        for (int k = 6; k >= 3; k--) begin
            q[k-3] = t[k];
            if (t[k]) t[k-:4] = t[k-:4] ^ G;
        end
        return q;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Encode d; junk drives the flush steps; pre>0 first starts a junk word aborted after pre steps.
    task automatic enc_run(input logic [3:0] d, input logic [2:0] junk, input int pre,
                           output logic [6:0] code, output int nval, output int lastpos);
        code = '0; nval = 0; lastpos = -1;
        for (int t = 0; t < pre + 8; t++) begin
            @(negedge clk);
            if (enc_valid) begin code = {code[5:0], enc_code}; nval++; end
            if (enc_last) lastpos = t;
            enc_start = (t == 0) || (t == pre);
            if (t < pre)            enc_bit = 1'($urandom);
            else if (t - pre < 4)   enc_bit = d[3-(t-pre)];
            else if (t - pre < 7)   enc_bit = junk[t-pre-4];
            else                    enc_bit = 1'b0;
        end
    endtask

    task automatic dec_run(input logic [6:0] w, input int pre,
                           output logic [3:0] q, output int nq, output logic err,
                           output logic [2:0] syn, output int donepos);
        q = '0; nq = 0; err = 1'b0; syn = '0; donepos = -1;
        for (int t = 0; t < pre + 8; t++) begin
            @(negedge clk);
            if (dec_qvalid) begin q = {q[2:0], dec_qbit}; nq++; end
            if (dec_done) begin err = dec_err; syn = dec_syn; donepos = t; end
            dec_start = (t == 0) || (t == pre);
            if (t < pre)          dec_bit = 1'($urandom);
            else if (t - pre < 7) dec_bit = w[6-(t-pre)];
            else                  dec_bit = 1'b0;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] code, w;
        logic [3:0] q;
        logic [2:0] syn;
        logic       err;
        int nval, lastpos, nq, dpos;

        void'($urandom(32'd2024));
        rst_n = 1'b0; enc_start = 1'b0; enc_bit = 1'b0; dec_start = 1'b0; dec_bit = 1'b0;
        repeat (3) @(negedge clk);
        // R8: outputs idle under reset
        chk({enc_code, enc_valid, enc_last, dec_qbit, dec_qvalid, dec_done, dec_err, dec_syn} == '0,
            "R8 reset", {enc_code, enc_valid, enc_last, dec_qbit, dec_qvalid, dec_done, dec_err, dec_syn}, 0);
        rst_n = 1'b1;

        // R1: directed codewords
        enc_run(4'b1011, 3'b000, 0, code, nval, lastpos);
        chk(code == 7'b1000101, "R1 1011", code, 7'b1000101);
        enc_run(4'b1111, 3'b000, 0, code, nval, lastpos);
        chk(code == 7'b1101001, "R1 1111", code, 7'b1101001);

        // R2: flush-slot values ignored
        enc_run(4'b0110, 3'b111, 0, code, nval, lastpos);
        chk(code == mulg(4'b0110), "R2 flush 111", code, mulg(4'b0110));
        enc_run(4'b1001, 3'b101, 0, code, nval, lastpos);
        chk(code == mulg(4'b1001), "R2 flush 101", code, mulg(4'b1001));

        // R1, R3: all data words with random flush noise
        for (int d = 0; d < 16; d++) begin
            enc_run(4'(d), 3'($urandom), 0, code, nval, lastpos);
            chk(code == mulg(4'(d)), "R1 product", code, mulg(4'(d)));
            chk(nval == 7 && lastpos == 7, "R3 last", 32'(nval * 16 + lastpos), 32'(7 * 16 + 7));
        end

        // R4, R5, R6: round trip and every single-bit error
        for (int d = 0; d < 16; d++) begin
            w = mulg(4'(d));
            dec_run(w, 0, q, nq, err, syn, dpos);
            chk(q == 4'(d) && nq == 4, "R4 quotient", {q, 4'(nq)}, {4'(d), 4'd4});
            chk(dpos == 7 && !err && syn == 3'b000, "R5 clean", {dpos[3:0], err, syn}, {4'd7, 4'b0});
            for (int b = 0; b < 7; b++) begin
                dec_run(w ^ (7'd1 << b), 0, q, nq, err, syn, dpos);
                chk(err && syn != 3'b000 && syn == remg(w ^ (7'd1 << b)), "R6 single error",
                    {err, syn}, {1'b1, remg(w ^ (7'd1 << b))});
            end
        end

        // R4, R5: random received words
        for (int n = 0; n < 40; n++) begin
            w = 7'($urandom);
            dec_run(w, 0, q, nq, err, syn, dpos);
            chk(syn == remg(w) && err == (remg(w) != 3'b000) && dpos == 7, "R5 syndrome",
                {err, syn}, {remg(w) != 3'b000, remg(w)});
            chk(q == quog(w), "R4 random quotient", q, quog(w));
        end

        // R7: abort mid-word, then restart
        enc_run(4'b1001, 3'b000, 3, code, nval, lastpos);
        chk(code == mulg(4'b1001) && lastpos == 10, "R7 enc restart", code, mulg(4'b1001));
        dec_run(mulg(4'b0101), 3, q, nq, err, syn, dpos);
        chk(q == 4'b0101 && nq == 4 && !err && dpos == 10, "R7 dec restart", {q, err}, {4'b0101, 1'b0});

        // R7: faulty word then clean word back to back
        dec_run(mulg(4'b1100) ^ 7'b0000100, 0, q, nq, err, syn, dpos);
        chk(err, "R7 first word faulty", err, 1);
        dec_run(mulg(4'b0011), 0, q, nq, err, syn, dpos);
        chk(!err && syn == 3'b000 && q == 4'b0011, "R7 back to back", {q, err, syn}, {4'b0011, 4'b0});

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule